// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a memory-mapped watchdog peripheral for a simple register bus. Software writes an address, write data and a write strobe; read data is driven combinationally from the address. Once enabled, an internal counter runs through a first, interrupt-stage interval. When that interval runs out, a sticky flag is set and, if allowed, an interrupt output goes high. The counter then starts a shorter second, reset-stage interval. If software has not reloaded the watchdog by the end of that interval, a reset output is raised and held.

Writes that change the configuration or reload the timer are guarded. A key value must first be written to a separate unlock register, and that unlock is good for one write only. A reload also needs its own key value. The interrupt interval comes from a non-uniform power-of-two table of sixteen codes. The reset interval comes from eight consecutive powers of two. A parameter selects a 16-bit or 32-bit counter. The 16-bit build saturates the interrupt code at 7.

The counter advances either on every clock or only on the cycles in which an external tick input is high. A control bit selects which.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the control and status registers read 0, both `wdt_irq` and `wdt_rst` are low, and offset 0x00 reads the `ID_VALUE` parameter.
- R2: Writing 0x5AA5 to offset 0x18 arms exactly one following write to offset 0x10 (control) or 0x14 (restart). A write to either offset without an armed unlock is ignored. Writes to other offsets neither use up nor clear the armed unlock.
- R3: The control word layout is: bit 0 enables, bit 1 selects the tick source, bit 2 gates the interrupt output, bit 3 gates the reset output, bits 7:4 hold the interrupt code and bits 10:8 hold the reset code. Control reads back bits 10:0, and every higher bit reads as zero.
- R4: With bit 1 set, status bit 0 (offset 0x1C) becomes 1 exactly 2^N clocks after an accepted enabling control write. N is 6, 8, 10, 11, 12, 13, 14 or 15 for codes 0 to 7, and 2*code+1 for codes 8 to 15. `wdt_irq` equals status bit 0 ANDed with control bit 2.
- R5: 2^(7+code) ticks after the interrupt interval runs out, `wdt_rst` rises if control bit 3 is set, and stays high through restarts until a stop or system reset.
- R6: Writing 0xCAFE to offset 0x14 while unlocked and enabled reloads the count to the start of the interrupt stage. Any other value changes nothing but still uses up the unlock.
- R7: Status bit 0 is sticky. Writing 1 to it clears it, writing 0 leaves it set, and no unlock is needed.
- R8: An accepted control write with bit 0 clear stops the timer and drives `wdt_irq` and `wdt_rst` low.
- R9: With control bit 1 clear, the counter advances only on clocks where `alt_tick` is high.
- R10: With `CNT_W` = 16, an interrupt code above 7 is stored and read back as 7.
- R11: Writes to offset 0x00 and to undefined offsets have no effect, and undefined offsets, 0x14 and 0x18 read as zero.
- R12: Any accepted enabling control write made while the timer runs restarts the count from the interrupt stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| alt_tick | input | 1 | Alternative count enable, used when control bit 1 is 0 |
| wdt_irq | output | 1 | Interrupt-stage output |
| wdt_rst | output | 1 | Reset-stage output, held once raised |

## Verification
The timing path is driven with five control words. Each word pairs a different interrupt code with a different reset code, and the two output enables are switched on and off in different combinations. Sampling one cycle before and at each expected edge catches a wrong table entry or an off-by-one count. Sampling with an enable bit cleared shows whether that bit gates only its own output.

Further sequences check the unlock rules. These include a write without an unlock, an unlock spent on a wrong restart key, and a status write placed between an unlock and its use. Each of these shows whether the one-shot key is being used up by the right writes. A run held on `alt_tick` shows whether the clock-select bit really stops counting. A 16-bit instance given the code-15 word shows whether the clamp is applied.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam logic [31:0] KEY_UNLOCK  = 32'h0000_5AA5;
   localparam logic [31:0] KEY_RESTART = 32'h0000_CAFE;

   localparam int OFS_ID     = 'h00;
   localparam int OFS_CTRL   = 'h10;
   localparam int OFS_RELOAD = 'h14;
   localparam int OFS_UNLOCK = 'h18;
   localparam int OFS_STATUS = 'h1C;

   localparam int CTRL_W = 11;

   // field order gives bit positions: en at bit 0, rst_code at 10:8
   typedef struct packed {
      logic [2:0] rst_code;
      logic [3:0] int_code;
      logic       rst_en;
      logic       int_en;
      logic       clk_sel;
      logic       en;
   } ctrl_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_INT  = 2'd1,
      ST_RST  = 2'd2,
      ST_DONE = 2'd3
   } stage_e;

   function automatic logic [4:0] int_exp(input logic [3:0] code);
      logic [4:0] e;
      if (code[3])           e = {code, 1'b1};
      else if (code == 4'd0) e = 5'd6;
      else if (code == 4'd1) e = 5'd8;
      else if (code == 4'd2) e = 5'd10;
      else                   e = 5'(code) + 5'd8;
      return e;
   endfunction

   function automatic logic [4:0] rst_exp(input logic [2:0] code);
      return 5'(code) + 5'd7;
   endfunction

endpackage

// File: rtl/wdog_intv_sel.sv
module wdog_intv_sel
   import wdog_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic [3:0]       int_code,
   input  logic [2:0]       rst_code,
   output logic [CNT_W-1:0] int_last,
   output logic [CNT_W-1:0] rst_last
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [4:0] ie;
   logic [4:0] re;

   always_comb begin
      ie = int_exp(int_code);
      re = rst_exp(rst_code);
      int_last = (ONE << ie) - ONE;
      rst_last = (ONE << re) - ONE;
      // R10
      exp_fit_chk: assert (32'(ie) < CNT_W)
         else $error("interrupt exponent exceeds counter width");
   end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          CNT_W    = 32,
   parameter logic [31:0] ID_VALUE = 32'h57D0_0C20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              int_expire,
   output ctrl_t             ctrl,
   output logic              sts,
   output logic              start,
   output logic              stop
);

   localparam int PAD_W = 32 - CTRL_W;

   logic  hit_ctrl, hit_reload, hit_unlock, hit_sts;
   logic  unlocked;
   logic  ctrl_acc;
   logic  reload_acc;
   logic  [3:0] wr_int_code;
   ctrl_t ctrl_wr;

   assign hit_ctrl   = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_reload = bus_we && (bus_addr == ADDR_W'(OFS_RELOAD));
   assign hit_unlock = bus_we && (bus_addr == ADDR_W'(OFS_UNLOCK));
   assign hit_sts    = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));

   // counter width variant decides whether the code saturates
   generate
      if (CNT_W == 16) begin : g_narrow
         assign wr_int_code = bus_wdata[7] ? 4'd7 : bus_wdata[7:4];
      end else begin : g_wide
         assign wr_int_code = bus_wdata[7:4];
      end
   endgenerate

   always_comb begin
      ctrl_wr          = ctrl_t'(bus_wdata[CTRL_W-1:0]);
      ctrl_wr.int_code = wr_int_code;
   end

   assign ctrl_acc   = hit_ctrl && unlocked;
   assign reload_acc = hit_reload && unlocked && (bus_wdata == KEY_RESTART) && ctrl.en;
   assign start      = (ctrl_acc && bus_wdata[0]) || reload_acc;
   assign stop       = ctrl_acc && !bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
      end else if (hit_unlock) begin
         unlocked <= (bus_wdata == KEY_UNLOCK);
      end else if (hit_ctrl || hit_reload) begin
         unlocked <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (ctrl_acc) begin
         ctrl <= ctrl_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts <= 1'b0;
      end else if (int_expire) begin
         sts <= 1'b1;
      end else if (hit_sts && bus_wdata[0]) begin
         sts <= 1'b0;
      end
   end

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_ID))          bus_rdata = ID_VALUE;
      else if (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata = {{PAD_W{1'b0}}, ctrl};
      else if (bus_addr == ADDR_W'(OFS_STATUS)) bus_rdata = {31'd0, sts};
      else                                      bus_rdata = 32'd0;
   end

   // R2
   locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctrl && !unlocked) |=> $stable(ctrl));

   // R2
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctrl || hit_reload) |=> !unlocked);

   // R7
   sts_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts) |-> $past(int_expire));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_sel,
   input  logic             rst_en,
   input  logic             alt_tick,
   input  logic [CNT_W-1:0] int_last,
   input  logic [CNT_W-1:0] rst_last,
   input  logic             start,
   input  logic             stop,
   output logic             int_expire,
   output logic             wdt_rst
);

   stage_e           stage;
   logic [CNT_W-1:0] cnt;
   logic             tick;
   logic             int_end;
   logic             rst_end;

   assign tick    = clk_sel || alt_tick;
   assign int_end = (stage == ST_INT) && tick && (cnt == int_last);
   assign rst_end = (stage == ST_RST) && tick && (cnt == rst_last);

   assign int_expire = int_end && !start && !stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage   <= ST_IDLE;
         cnt     <= '0;
         wdt_rst <= 1'b0;
      end else if (stop) begin
         stage   <= ST_IDLE;
         cnt     <= '0;
         wdt_rst <= 1'b0;
      end else if (start) begin
         stage <= ST_INT;
         cnt   <= '0;
      end else begin
         case (stage)
            ST_INT: begin
               if (int_end) begin
                  stage <= ST_RST;
                  cnt   <= '0;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RST: begin
               if (rst_end) begin
                  stage   <= ST_DONE;
                  cnt     <= '0;
                  wdt_rst <= wdt_rst | rst_en;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // R8
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (stage == ST_IDLE) && !wdt_rst);

   // R5
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> $past(stage == ST_RST && rst_en));

   // R5
   rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wdt_rst) && !$past(stop)) |-> wdt_rst);

   // R9
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stage == ST_INT) && $past(!tick) && $past(!start) && $past(!stop)) |-> $stable(cnt));

   // R4
   int_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage == ST_INT) |-> (cnt <= int_last));

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
   import wdog_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          CNT_W    = 32,
   parameter logic [31:0] ID_VALUE = 32'h57D0_0C20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              alt_tick,
   output logic              wdt_irq,
   output logic              wdt_rst
);

   generate
      if (CNT_W != 16 && CNT_W != 32) begin : g_bad_width
         $error("CNT_W must be 16 or 32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x1C");
      end
   endgenerate

   ctrl_t            ctrl;
   logic             sts;
   logic             start;
   logic             stop;
   logic             int_expire;
   logic [CNT_W-1:0] int_last;
   logic [CNT_W-1:0] rst_last;

   wdog_regs #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .ID_VALUE (ID_VALUE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .int_expire (int_expire),
      .ctrl       (ctrl),
      .sts        (sts),
      .start      (start),
      .stop       (stop)
   );

   wdog_intv_sel #(
      .CNT_W (CNT_W)
   ) u_sel (
      .int_code (ctrl.int_code),
      .rst_code (ctrl.rst_code),
      .int_last (int_last),
      .rst_last (rst_last)
   );

   wdog_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_sel    (ctrl.clk_sel),
      .rst_en     (ctrl.rst_en),
      .alt_tick   (alt_tick),
      .int_last   (int_last),
      .rst_last   (rst_last),
      .start      (start),
      .stop       (stop),
      .int_expire (int_expire),
      .wdt_rst    (wdt_rst)
   );

   assign wdt_irq = sts && ctrl.int_en;

   // R4
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_irq) |-> ctrl.int_en && sts);

endmodule

// File: tb/wdog_twostage_tb.sv
`timescale 1ns/1ps
module wdog_twostage_tb;

   localparam logic [31:0] ID = 32'h1234_ABCD;
   localparam logic [7:0] A_ID = 8'h00, A_CTRL = 8'h10, A_RS = 8'h14,
                          A_UL = 8'h18, A_STS = 8'h1C, A_UND = 8'h04;
   localparam logic [31:0] UL = 32'h5AA5, RS = 32'hCAFE;

   localparam int NV = 5;
   localparam logic [31:0] V_CTRL [NV] = '{32'h00F, 32'h11F, 32'h02B, 32'h237, 32'h30F};
   localparam int          V_TI   [NV] = '{64, 256, 1024, 2048, 64};
   localparam int          V_TR   [NV] = '{128, 256, 128, 512, 1024};

   logic        clk = 0, rst_n = 0, bus_we = 0, alt_tick = 0;
   logic [7:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, rdata, rdata16, rd;
   logic        irq, rst, irq16, rst16;
   int          tests = 0, fails = 0;

   always #4 clk = ~clk;

   wdog_twostage #(.ADDR_W(8), .CNT_W(32), .ID_VALUE(ID)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(rdata), .alt_tick(alt_tick),
      .wdt_irq(irq), .wdt_rst(rst));

   wdog_twostage #(.ADDR_W(8), .CNT_W(16), .ID_VALUE(ID)) u_dut16 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(rdata16), .alt_tick(alt_tick),
      .wdt_irq(irq16), .wdt_rst(rst16));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rdreg(input logic [7:0] a);
      bus_addr = a;
      #1;
      rd = rdata;
   endtask

   task automatic pwr(input logic [7:0] a, input logic [31:0] d);
      wr(A_UL, UL);
      wr(a, d);
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      waitn(3);
      rst_n = 1;
      waitn(1);

      // R1 reset state
      rdreg(A_CTRL); check("R1 ctrl", rd, 0);
      rdreg(A_STS);  check("R1 status", rd, 0);
      rdreg(A_ID);   check("R1 id", rd, ID);
      check("R1 irq", irq, 0);
      check("R1 rst", rst, 0);

      // R2 locked write ignored, status write between unlock and use
      wr(A_CTRL, 32'h0F0);
      rdreg(A_CTRL); check("R2 no unlock", rd, 0);
      wr(A_UL, UL);
      wr(A_STS, 32'h1);
      wr(A_CTRL, 32'h0F0);
      rdreg(A_CTRL); check("R2 unlocked write", rd, 32'h0F0);
      wr(A_CTRL, 32'h0A0);
      rdreg(A_CTRL); check("R2 one shot", rd, 32'h0F0);

      // R3 / R10 field readback and narrow clamp
      pwr(A_CTRL, 32'hFFFF_FFFF);
      rdreg(A_CTRL); check("R3 readback", rd, 32'h7FF);
      check("R10 clamp", rdata16, 32'h77F);
      pwr(A_CTRL, 0);

      // R11 id and undefined offsets
      wr(A_ID, 32'h0);
      rdreg(A_ID);  check("R11 id write", rd, ID);
      wr(A_UND, 32'hFFFF_FFFF);
      rdreg(A_UND); check("R11 undefined", rd, 0);
      rdreg(A_RS);  check("R11 restart reads 0", rd, 0);
      rdreg(A_UL);  check("R11 unlock reads 0", rd, 0);

      // R4 R5 table walk
      for (int i = 0; i < NV; i++) begin
         pwr(A_CTRL, 0);
         wr(A_STS, 1);
         pwr(A_CTRL, V_CTRL[i]);
         waitn(V_TI[i] - 1);
         rdreg(A_STS); check("R4 status early", rd, 0);
         check("R4 irq early", irq, 0);
         waitn(1);
         rdreg(A_STS); check("R4 status at expiry", rd, 1);
         check("R4 irq gate", irq, V_CTRL[i][2]);
         waitn(V_TR[i] - 1);
         check("R5 rst early", rst, 0);
         waitn(1);
         check("R5 rst at expiry", rst, V_CTRL[i][3]);
      end

      // R5 hold through restart, R8 stop
      check("R5 held", rst, 1);
      pwr(A_RS, RS);
      waitn(10);
      check("R5 held after restart", rst, 1);
      pwr(A_CTRL, 0);
      check("R8 rst low", rst, 0);
      check("R8 irq low", irq, 0);

      // R6 good restart
      wr(A_STS, 1);
      pwr(A_CTRL, 32'h00F);
      waitn(20);
      pwr(A_RS, RS);
      waitn(63);
      check("R6 reload delays irq", irq, 0);
      waitn(1);
      check("R6 irq after reload", irq, 1);

      // R6 wrong key consumes unlock
      pwr(A_CTRL, 0);
      wr(A_STS, 1);
      pwr(A_CTRL, 32'h00F);
      waitn(20);
      pwr(A_RS, 32'h1234);
      wr(A_RS, RS);
      waitn(40);
      check("R6 bad key no reload", irq, 0);
      waitn(1);
      check("R6 bad key no reload expiry", irq, 1);

      // R12 rewrite while running
      pwr(A_CTRL, 0);
      wr(A_STS, 1);
      pwr(A_CTRL, 32'h00F);
      waitn(40);
      pwr(A_CTRL, 32'h00F);
      waitn(63);
      check("R12 restart by rewrite", irq, 0);
      waitn(1);
      check("R12 expiry after rewrite", irq, 1);

      // R9 alternative tick
      pwr(A_CTRL, 0);
      wr(A_STS, 1);
      pwr(A_CTRL, 32'h005);
      waitn(100);
      check("R9 no tick no count", irq, 0);
      alt_tick = 1;
      waitn(63);
      check("R9 63 ticks", irq, 0);
      waitn(1);
      check("R9 64 ticks", irq, 1);
      alt_tick = 0;

      // R7 write-one-to-clear
      wr(A_STS, 0);
      rdreg(A_STS); check("R7 write 0 keeps", rd, 1);
      wr(A_STS, 1);
      rdreg(A_STS); check("R7 write 1 clears", rd, 0);
      check("R7 irq drops", irq, 0);

      pwr(A_CTRL, 0);
      finish_run();
   end

endmodule